// File: doc/BRIEF.md
# SPI Burst Acquisition Master

This block reads a fixed-size batch of samples from one SPI slave and writes them into a sample memory. A controller hands it a grant to begin. The master then runs a burst of read-only word transfers. Each received word goes to the next memory address, starting at address zero. When the last word is stored, the master returns the grant with a done pulse. After that, the controller owns the memory contents again until it issues a new grant.

The serial clock idles low. The slave's data is sampled on rising clock edges, and each word arrives most significant bit first. One build-time parameter sets both the high time and the low time of the serial clock, counted in system clocks. Chip select drops for each word. Between words it rises and stays high for three half-periods. The MISO input passes through a synchroniser before it is used. The master does not send any data, so MOSI stays low.

Top module: `spi_burst_reader`

## Requirements
- R1: While reset is applied, chip select is high, the serial clock is low and the pin output enable is low. The output enable first rises at a point where chip select is already high.
- R2: While the grant is low and no burst has started, chip select stays high and no memory write occurs.
- R3: The serial clock high and low phases each last exactly HALF_CLKS system clocks. The first rising edge comes HALF_CLKS clocks after chip select falls.
- R4: Each chip-select-low window holds exactly WORD_W rising clock edges. The bit on MISO at the k-th rising edge (k counting from 1) lands at bit position WORD_W-k of the stored word.
- R5: Between two words of one burst, chip select stays high for exactly 3*HALF_CLKS system clocks.
- R6: The memory write enable is a one-cycle strobe. It fires in the first cycle that chip select is high after a word's last bit. The address is the word's index within the burst, starting at 0.
- R7: One burst stores exactly NUM_WORDS words. After the last write, done pulses high for a single cycle.
- R8: Once a burst has started, dropping the grant has no effect. The burst still stores all NUM_WORDS words.
- R9: After done, no new burst begins while the grant stays high. A new burst starts only after the grant has gone low and then high again.
- R10: MOSI is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Controller hands the memory to the master while high |
| done | output | 1 | One-cycle pulse when the burst has been stored |
| mem_we | output | 1 | Sample memory write strobe |
| mem_addr | output | $clog2(NUM_WORDS) | Sample memory write address |
| mem_wdata | output | WORD_W | Received word |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out, held low |
| spi_miso | input | 1 | Serial data in from the slave |
| spi_oe | output | 1 | Output enable for the chip select, clock and MOSI pins |

## Verification
The bench models the slave at the pins and runs full bursts with three data patterns. An incrementing counter exposes mistakes in the low bits and in word ordering. A scrambled multiplicative hash catches any bit permutation or missed shift. An alternating all-ones/all-zeros word with a walking single bit inverted pins down each bit position and any stuck serial line. Every phase of the serial clock and every gap in chip select is timed against the half-period. The grant is toggled in three ways: it is dropped mid-burst, held high past done, and cycled low and high again. These separate the burst-completion rule from the rule that a new burst needs a fresh grant.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    // Chip select stays high for this many half-periods between words.
    localparam int GAP_HALVES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_HOLD
    } eng_state_e;

endpackage

// File: rtl/spi_half_timer.sv
// Free-running half-period timer: tick is high for one cycle every HALF_CLKS cycles.
// HALF_CLKS must be at least 2.
module spi_half_timer #(
    parameter int HALF_CLKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(HALF_CLKS - 1));
        cnt_d = (clear || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> !tick);

endmodule

// File: rtl/spi_in_sync.sv
// Multi-stage synchroniser for the asynchronous serial input (STAGES >= 2).
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
        q    = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/spi_burst_engine.sv
// Burst sequencer: grant handshake, chip select, serial clock, capture and memory write.
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 128,
    parameter int SYNC_STG  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          grant,
    input  logic                          tick,
    input  logic                          miso_s,
    output logic                          timer_clear,
    output logic                          cs_n,
    output logic                          sclk,
    output logic                          pin_oe,
    output logic                          we,
    output logic [$clog2(NUM_WORDS)-1:0]  addr,
    output logic [WORD_W-1:0]             wdata,
    output logic                          done
);
    localparam int BW  = $clog2(WORD_W);
    localparam int AW  = $clog2(NUM_WORDS);
    localparam int GW  = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

    typedef struct packed {
        eng_state_e          st;
        logic                cs_n;
        logic                sclk;
        logic                oe;
        logic [BW-1:0]       bit_idx;
        logic [AW-1:0]       word_idx;
        logic [GW-1:0]       gap_cnt;
        logic [SYNC_STG-1:0] pipe;
        logic [WORD_W-1:0]   shreg;
        logic                we;
        logic [WORD_W-1:0]   wdata;
        logic                done;
    } eng_t;

    eng_t q_r, d_r;
    logic rise;
    logic [WORD_W-1:0] sh;

    always_comb begin
        d_r         = q_r;
        d_r.we      = 1'b0;
        d_r.done    = 1'b0;
        d_r.oe      = 1'b1;
        timer_clear = 1'b0;
        rise        = 1'b0;

        // Capture the synchronised MISO bit SYNC_STG cycles after each rising edge.
        sh = q_r.shreg;
        if (q_r.pipe[SYNC_STG-1]) sh = {q_r.shreg[WORD_W-2:0], miso_s};
        d_r.shreg = sh;

        unique case (q_r.st)
            ST_IDLE: begin
                if (grant && q_r.oe) begin
                    d_r.cs_n    = 1'b0;
                    d_r.bit_idx = BW'(WORD_W - 1);
                    d_r.st      = ST_LEAD;
                    timer_clear = 1'b1;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (tick) begin
                    d_r.sclk = 1'b1;
                    rise     = 1'b1;
                    d_r.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d_r.sclk = 1'b0;
                    if (q_r.bit_idx == '0) begin
                        d_r.cs_n    = 1'b1;
                        d_r.we      = 1'b1;
                        d_r.wdata   = sh;
                        d_r.gap_cnt = '0;
                        d_r.st      = ST_GAP;
                    end else begin
                        d_r.bit_idx = q_r.bit_idx - 1'b1;
                        d_r.st      = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q_r.gap_cnt == GW'(GAP_HALVES - 1)) begin
                        if (q_r.word_idx == AW'(NUM_WORDS - 1)) begin
                            d_r.word_idx = '0;
                            d_r.done     = 1'b1;
                            d_r.st       = ST_HOLD;
                        end else begin
                            d_r.word_idx = q_r.word_idx + 1'b1;
                            d_r.cs_n     = 1'b0;
                            d_r.bit_idx  = BW'(WORD_W - 1);
                            d_r.st       = ST_LEAD;
                        end
                    end else begin
                        d_r.gap_cnt = q_r.gap_cnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (!grant) d_r.st = ST_IDLE;
            end
            default: d_r.st = ST_IDLE;
        endcase

        d_r.pipe = {q_r.pipe[SYNC_STG-2:0], rise};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r      <= '0;
            q_r.st   <= ST_IDLE;
            q_r.cs_n <= 1'b1;
        end else begin
            q_r <= d_r;
        end
    end

    assign cs_n   = q_r.cs_n;
    assign sclk   = q_r.sclk;
    assign pin_oe = q_r.oe;
    assign we     = q_r.we;
    assign addr   = q_r.word_idx;
    assign wdata  = q_r.wdata;
    assign done   = q_r.done;

    // R1
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_r.oe |-> q_r.cs_n);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r.st == ST_IDLE && !grant) |=> q_r.cs_n);
    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_r.sclk |-> !q_r.cs_n);
    // R6
    wr_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_r.we |-> (q_r.cs_n && !$past(q_r.cs_n)));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_r.done |=> !q_r.done);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r.st == ST_HOLD && grant) |=> (q_r.st == ST_HOLD && q_r.cs_n));

endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 128,
    parameter int HALF_CLKS = 50,
    parameter int SYNC_STG  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          grant,
    output logic                          done,
    output logic                          mem_we,
    output logic [$clog2(NUM_WORDS)-1:0]  mem_addr,
    output logic [WORD_W-1:0]             mem_wdata,
    output logic                          spi_cs_n,
    output logic                          spi_sclk,
    output logic                          spi_mosi,
    input  logic                          spi_miso,
    output logic                          spi_oe
);
    logic tick, timer_clear, miso_s;

    spi_half_timer #(.HALF_CLKS(HALF_CLKS)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .tick  (tick)
    );

    spi_in_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (spi_miso),
        .q     (miso_s)
    );

    spi_burst_engine #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .SYNC_STG  (SYNC_STG)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (grant),
        .tick        (tick),
        .miso_s      (miso_s),
        .timer_clear (timer_clear),
        .cs_n        (spi_cs_n),
        .sclk        (spi_sclk),
        .pin_oe      (spi_oe),
        .we          (mem_we),
        .addr        (mem_addr),
        .wdata       (mem_wdata),
        .done        (done)
    );

    // R10: the master never transmits.
    assign spi_mosi = 1'b0;

endmodule

// File: tb/test_spi_burst_reader.sv
`timescale 1ns/1ps
module test_spi_burst_reader;
    localparam int W    = 32;
    localparam int NUM  = 128;
    localparam int HALF = 2;
    localparam int AW   = $clog2(NUM);

    logic clk = 1'b0;
    logic rst_n, grant, spi_miso;
    logic done, mem_we, spi_cs_n, spi_sclk, spi_mosi, spi_oe;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;

    always #2 clk = ~clk;

    spi_burst_reader #(.WORD_W(W), .NUM_WORDS(NUM), .HALF_CLKS(HALF)) i_spi_burst_reader (
        .clk(clk), .rst_n(rst_n), .grant(grant), .done(done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_oe(spi_oe)
    );

    int checks = 0, fails = 0;
    int burst = 0, wr_cnt = 0, tot_wr = 0, done_cnt = 0, cs_falls = 0, mosi_bad = 0;
    int hi_len = 0, lo_len = 0, rises = 0, gap_len = 0, sbit = 0, swi = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_done = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int b, input int i);
        logic [W-1:0] v;
        case (b % 3)
            0: v = W'(i);
            1: v = W'(i) * 32'h9E37_79B9 ^ 32'h5A5A_C3C3;
            default: v = ((i % 2) ? {W{1'b1}} : {W{1'b0}}) ^ (W'(1) << (i % W));
        endcase
        return v;
    endfunction

    // Slave model and pin monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_mosi) mosi_bad++;
            // clock phase widths (R3)
            if (p_sclk && !spi_sclk) begin
                check(hi_len == HALF, "R3 sclk high width", hi_len, HALF);
                hi_len = 0;
            end
            if (!p_sclk && spi_sclk) begin
                check(lo_len == HALF, "R3 sclk low/lead width", lo_len, HALF);
                lo_len = 0;
                rises++;
            end
            if (p_cs && !spi_cs_n) begin
                cs_falls++;
                lo_len = 0;
                if (wr_cnt > 0) check(gap_len == 3 * HALF, "R5 cs gap", gap_len, 3 * HALF);
                sbit = W - 1;
                spi_miso = pat(burst, swi)[sbit];
            end
            if (!p_cs && spi_cs_n) begin
                check(rises == W, "R4 rising edges per word", rises, W);
                rises = 0;
                gap_len = 0;
                swi++;
            end else if (p_sclk && !spi_sclk && !spi_cs_n && sbit > 0) begin
                sbit--;
                spi_miso = pat(burst, swi)[sbit];
            end
            if (spi_sclk) hi_len++;
            if (!spi_cs_n && !spi_sclk) lo_len++;
            if (spi_cs_n) gap_len++;
            // memory writes (R4, R6)
            if (mem_we) begin
                check(int'(mem_addr) == wr_cnt, "R6 write address", mem_addr, wr_cnt);
                check(mem_wdata == pat(burst, wr_cnt), "R4 stored word", mem_wdata, pat(burst, wr_cnt));
                check(spi_cs_n && !p_cs, "R6 strobe with cs rise", {p_cs, spi_cs_n}, 2'b01);
                wr_cnt++;
                tot_wr++;
            end
            // done (R7)
            if (done) begin
                check(wr_cnt == NUM, "R7 words per burst", wr_cnt, NUM);
                check(!p_done, "R7 done single cycle", p_done, 0);
                if (!p_done) begin
                    done_cnt++;
                    wr_cnt = 0;
                    swi = 0;
                    burst++;
                end
            end
        end
        p_cs   = spi_cs_n;
        p_sclk = spi_sclk;
        p_done = done;
    end

    task automatic wait_done(input int n);
        for (int k = 0; k < 40000 && done_cnt < n; k++) @(negedge clk);
        check(done_cnt == n, "R7 burst completion", done_cnt, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int falls0;
        rst_n = 1'b0; grant = 1'b0; spi_miso = 1'b0;
        repeat (5) @(negedge clk);
        check(spi_cs_n && !spi_sclk && !spi_oe, "R1 reset pin state",
              {spi_cs_n, spi_sclk, spi_oe}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_oe && spi_cs_n, "R1 oe with cs preset", {spi_oe, spi_cs_n}, 2'b11);

        repeat (60) @(negedge clk);
        check(cs_falls == 0 && tot_wr == 0, "R2 quiet without grant", cs_falls, 0);

        // burst 0: counter pattern, grant dropped mid-burst
        grant = 1'b1;
        repeat (2000) @(negedge clk);
        grant = 1'b0;
        wait_done(1);
        check(tot_wr == NUM, "R8 burst completes after grant drop", tot_wr, NUM);

        // burst 1: hashed pattern, grant held after done
        repeat (10) @(negedge clk);
        grant = 1'b1;
        wait_done(2);
        falls0 = cs_falls;
        repeat (400) @(negedge clk);
        check(cs_falls == falls0 && tot_wr == 2 * NUM, "R9 no restart while grant held",
              cs_falls - falls0, 0);

        // burst 2: walking-bit pattern after re-grant
        grant = 1'b0;
        repeat (5) @(negedge clk);
        grant = 1'b1;
        wait_done(3);
        grant = 1'b0;
        check(tot_wr == 3 * NUM, "R9 re-grant starts new burst", tot_wr, 3 * NUM);
        repeat (20) @(negedge clk);
        check(mosi_bad == 0, "R10 mosi low", mosi_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule